// File: doc/BRIEF.md
# Device Power State Controller

This block follows the power state of a network controller function. It has five states: a held-in-reset state, a held-in-reset state with power-down disabled, an uninitialized active state, a fully active state and a sleep (D3hot) state. It is driven by the chip's internal power-on reset, by the active-low platform reset pin, by an in-band hot reset indication and by software writes to the power-state field of the PCI power management registers. It also exchanges a request and a done flag with a non-volatile configuration loader. From these it decides when the PHY is held in reset and when the PHY should drop to a lower link speed. It also drives the APM wake enable and names the link low-power target (L2 or L3) for the next platform reset.

The configuration loader delivers four bits when it raises its done flag: APM wake enable, pass-through manageability enable, PME enable and a disable-power-down bit. These bits are captured in sticky registers. The internal power-on reset clears them. The platform reset does not. A new load overwrites them. Link training, the serial protocol of the non-volatile memory and PHY auto-negotiation all sit outside this block.

Top module: `pwr_state_ctrl`

## Requirements
- R1: While `rst` is high and one cycle after it falls, `state` is 0 (held), `cfg_req` is 1, and `wake_en`, `phy_slow` and `phy_rst` are 0. State codes: 0 held, 1 held-off, 2 uninitialized, 3 active, 4 sleep.
- R2: In state 0 with `plat_rst_n` low and no load pending (`cfg_req` 0), the next state is 1 exactly when the loaded manageability bit is 0, the loaded PME bit is 0 and the loaded disable-power-down bit is 1. Otherwise the state stays 0. While a load is pending the state stays 0.
- R3: In state 1 the state changes only when `plat_rst_n` is high. Hot reset and power-state writes have no effect there.
- R4: A load that completes (`cfg_done` high while `cfg_req` is 1) in state 0 sets `wake_en` and `phy_slow` to the delivered APM bit on the same edge.
- R5: `plat_rst_n` low in state 2, 3 or 4 gives state 0 on the next edge, with `phy_slow` equal to the OR of the loaded manageability bit, the loaded PME bit and the current `wake_en`.
- R6: `lp_l3` is 1 (target L3) when the loaded PME bit is 0, and 0 (target L2) when it is 1.
- R7: State 2 is entered from state 0 or 1 when `plat_rst_n` is high, from state 2, 3 or 4 on `hot_rst`, and from state 4 on a power-state write of 2'b00. Every entry clears `wake_en` and `phy_slow` and sets `cfg_req` to 1 on the same edge.
- R8: In state 2, `phy_rst` is 1 while `cfg_req` is 1. A load that completes there sets `wake_en` to the delivered APM bit.
- R9: State 2 moves to state 3 on the edge after which both `cfg_req` is 0 and `link_up` is 1 are seen. It does not move before.
- R10: In state 3, a power-state write (`pm_wr` high) of 2'b11 gives state 4. Writes of 2'b00, 2'b01 and 2'b10 leave state 3 unchanged. A 2'b00 write acts only in state 4.
- R11: `plat_rst_n` low takes priority over `hot_rst` and over power-state writes in every state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Internal power-on reset, synchronous, active high |
| plat_rst_n | input | 1 | Platform reset, active low |
| hot_rst | input | 1 | In-band hot reset indication |
| cfg_done | input | 1 | Configuration load finished; bits below valid |
| cfg_apm_en | input | 1 | Loaded APM wake enable |
| cfg_mng_en | input | 1 | Loaded pass-through manageability enable |
| cfg_pme_en | input | 1 | Loaded PME enable (any function) |
| cfg_pd_dis | input | 1 | Loaded disable-power-down bit |
| link_up | input | 1 | Link established indication |
| pm_wr | input | 1 | Software write strobe to the power-state field |
| pm_wr_data | input | 2 | Value written to the power-state field |
| state | output | 3 | Current power state code |
| cfg_req | output | 1 | Configuration load requested / pending |
| phy_rst | output | 1 | Hold PHY in reset |
| phy_slow | output | 1 | Request PHY to negotiate a lower link speed |
| wake_en | output | 1 | APM wake enable |
| lp_l3 | output | 1 | Link low-power target: 1 = L3, 0 = L2 |

## Verification
The bench sweeps all sixteen combinations of the four loaded bits. It covers the power-down-disable decision both at load completion while held and at a later platform reset. A design that ignored the pending load, or that tested the wrong polarity of one bit, would enter or skip the held-off state on the wrong combinations. The bench also fires hot reset and power-state writes together with the platform reset, and into the held-off state, to catch a wrong priority. It checks that 2'b00 writes outside sleep do nothing and that `link_up` alone cannot finish initialization. It compares the PHY slow-down request against the OR rule on every path back into reset, so a design that dropped the wake term or kept a stale value would be caught.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

    localparam int ST_W = 3;
    localparam int PM_W = 2;

    localparam logic [PM_W-1:0] PM_CODE_ON    = '0;
    localparam logic [PM_W-1:0] PM_CODE_SLEEP = '1;

    typedef enum logic [ST_W-1:0] {
        PS_HELD     = 3'd0,
        PS_HELD_OFF = 3'd1,
        PS_UNINIT   = 3'd2,
        PS_ACTIVE   = 3'd3,
        PS_SLEEP    = 3'd4
    } pstate_e;

    typedef struct packed {
        logic apm;
        logic mng;
        logic pme;
        logic pd_dis;
    } nvcfg_t;

    // Power-down may be skipped only with no manageability, no PME and the disable bit set
    function automatic logic off_allowed(input nvcfg_t c);
        return !c.mng && !c.pme && c.pd_dis;
    endfunction

    // Slow link request when dropping back into reset from an operating state
    function automatic logic slow_on_hold(input nvcfg_t c, input logic wake);
        return c.mng | c.pme | wake;
    endfunction

    function automatic logic is_operating(input pstate_e s);
        return (s == PS_UNINIT) || (s == PS_ACTIVE) || (s == PS_SLEEP);
    endfunction

endpackage

// File: rtl/pwr_cfg_loader.sv
module pwr_cfg_loader
    import pwr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   restart,
    input  logic   done,
    input  nvcfg_t cfg_in,
    output logic   pend,
    output logic   capture,
    output nvcfg_t cfg_q
);

    // A restart in the same cycle as done wins: the load begins again
    assign capture = done && pend && !restart;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend  <= 1'b1;
            cfg_q <= '0;
        end else if (restart) begin
            pend  <= 1'b1;
        end else if (capture) begin
            pend  <= 1'b0;
            cfg_q <= cfg_in;
        end
    end

endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
    import pwr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            plat_rst_n,
    input  logic            hot_rst,
    input  logic            pm_wr,
    input  logic [PM_W-1:0] pm_wr_data,
    input  logic            link_up,
    input  logic            pend,
    input  nvcfg_t          cfg_q,
    output pstate_e         state_q,
    output logic            restart,
    output logic            enter_held
);

    pstate_e nxt;
    logic    wr_on;
    logic    wr_sleep;

    assign wr_on    = pm_wr && (pm_wr_data == PM_CODE_ON);
    assign wr_sleep = pm_wr && (pm_wr_data == PM_CODE_SLEEP);

    always_comb begin
        nxt        = state_q;
        restart    = 1'b0;
        enter_held = 1'b0;
        if (!plat_rst_n) begin
            // platform reset outranks every other cause
            unique case (state_q)
                PS_HELD: begin
                    if (!pend && off_allowed(cfg_q)) nxt = PS_HELD_OFF;
                end
                PS_HELD_OFF: nxt = PS_HELD_OFF;
                default: begin
                    nxt        = PS_HELD;
                    enter_held = 1'b1;
                end
            endcase
        end else begin
            unique case (state_q)
                PS_HELD, PS_HELD_OFF: begin
                    nxt     = PS_UNINIT;
                    restart = 1'b1;
                end
                PS_UNINIT: begin
                    if (hot_rst) begin
                        restart = 1'b1;
                    end else if (!pend && link_up) begin
                        nxt = PS_ACTIVE;
                    end
                end
                PS_ACTIVE: begin
                    if (hot_rst) begin
                        nxt     = PS_UNINIT;
                        restart = 1'b1;
                    end else if (wr_sleep) begin
                        nxt = PS_SLEEP;
                    end
                end
                PS_SLEEP: begin
                    if (hot_rst || wr_on) begin
                        nxt     = PS_UNINIT;
                        restart = 1'b1;
                    end
                end
                default: begin
                    nxt = PS_HELD;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= PS_HELD;
        else     state_q <= nxt;
    end

endmodule

// File: rtl/pwr_out.sv
module pwr_out
    import pwr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  pstate_e state_q,
    input  logic    restart,
    input  logic    enter_held,
    input  logic    capture,
    input  logic    pend,
    input  logic    apm_in,
    input  nvcfg_t  cfg_q,
    output logic    wake_en,
    output logic    phy_slow,
    output logic    phy_rst,
    output logic    lp_l3
);

    always_ff @(posedge clk) begin
        if (rst) begin
            wake_en <= 1'b0;
        end else if (restart) begin
            wake_en <= 1'b0;
        end else if (capture) begin
            wake_en <= apm_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phy_slow <= 1'b0;
        end else if (restart) begin
            phy_slow <= 1'b0;
        end else if (enter_held) begin
            phy_slow <= slow_on_hold(cfg_q, wake_en);
        end else if (capture && (state_q == PS_HELD)) begin
            phy_slow <= apm_in;
        end
    end

    assign phy_rst = (state_q == PS_UNINIT) && pend;
    assign lp_l3   = !cfg_q.pme;

endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
    import pwr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            plat_rst_n,
    input  logic            hot_rst,
    input  logic            cfg_done,
    input  logic            cfg_apm_en,
    input  logic            cfg_mng_en,
    input  logic            cfg_pme_en,
    input  logic            cfg_pd_dis,
    input  logic            link_up,
    input  logic            pm_wr,
    input  logic [PM_W-1:0] pm_wr_data,
    output logic [ST_W-1:0] state,
    output logic            cfg_req,
    output logic            phy_rst,
    output logic            phy_slow,
    output logic            wake_en,
    output logic            lp_l3
);

    nvcfg_t  cfg_in;
    nvcfg_t  cfg_q;
    pstate_e state_q;
    logic    pend;
    logic    capture;
    logic    restart;
    logic    enter_held;

    assign cfg_in = '{apm: cfg_apm_en, mng: cfg_mng_en, pme: cfg_pme_en, pd_dis: cfg_pd_dis};

    pwr_cfg_loader u_loader (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .done    (cfg_done),
        .cfg_in  (cfg_in),
        .pend    (pend),
        .capture (capture),
        .cfg_q   (cfg_q)
    );

    pwr_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .plat_rst_n (plat_rst_n),
        .hot_rst    (hot_rst),
        .pm_wr      (pm_wr),
        .pm_wr_data (pm_wr_data),
        .link_up    (link_up),
        .pend       (pend),
        .cfg_q      (cfg_q),
        .state_q    (state_q),
        .restart    (restart),
        .enter_held (enter_held)
    );

    pwr_out u_out (
        .clk        (clk),
        .rst        (rst),
        .state_q    (state_q),
        .restart    (restart),
        .enter_held (enter_held),
        .capture    (capture),
        .pend       (pend),
        .apm_in     (cfg_apm_en),
        .cfg_q      (cfg_q),
        .wake_en    (wake_en),
        .phy_slow   (phy_slow),
        .phy_rst    (phy_rst),
        .lp_l3      (lp_l3)
    );

    assign state   = state_q;
    assign cfg_req = pend;

endmodule

// File: rtl/pwr_state_chk.sv
module pwr_state_chk
    import pwr_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            plat_rst_n,
    input logic            hot_rst,
    input logic            link_up,
    input logic            pm_wr,
    input logic [PM_W-1:0] pm_wr_data,
    input logic [ST_W-1:0] state,
    input logic            cfg_req,
    input logic            phy_rst,
    input logic            phy_slow,
    input logic            wake_en
);

    a_r2_hold_while_loading: assert property (@(posedge clk) disable iff (rst)
        (state == PS_HELD && !plat_rst_n && cfg_req) |=> state == PS_HELD);

    a_r3_off_sticks: assert property (@(posedge clk) disable iff (rst)
        (state == PS_HELD_OFF && !plat_rst_n) |=> state == PS_HELD_OFF);

    a_r7_entry_clears: assert property (@(posedge clk) disable iff (rst)
        (state == PS_UNINIT && $past(state) != PS_UNINIT) |-> (cfg_req && !wake_en && !phy_slow));

    a_r8_phy_held: assert property (@(posedge clk) disable iff (rst)
        (state == PS_UNINIT && cfg_req) |-> phy_rst);

    a_r9_no_early_active: assert property (@(posedge clk) disable iff (rst)
        (state == PS_UNINIT && plat_rst_n && (cfg_req || !link_up)) |=> state == PS_UNINIT);

    a_r10_sleep_on_write: assert property (@(posedge clk) disable iff (rst)
        (state == PS_ACTIVE && plat_rst_n && !hot_rst && pm_wr && pm_wr_data == PM_CODE_SLEEP)
        |=> state == PS_SLEEP);

    a_r11_plat_first: assert property (@(posedge clk) disable iff (rst)
        (!plat_rst_n && (state == PS_UNINIT || state == PS_ACTIVE || state == PS_SLEEP))
        |=> state == PS_HELD);

endmodule

bind pwr_state_ctrl pwr_state_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .plat_rst_n (plat_rst_n),
    .hot_rst    (hot_rst),
    .link_up    (link_up),
    .pm_wr      (pm_wr),
    .pm_wr_data (pm_wr_data),
    .state      (state),
    .cfg_req    (cfg_req),
    .phy_rst    (phy_rst),
    .phy_slow   (phy_slow),
    .wake_en    (wake_en)
);

// File: tb/test_pwr_state_ctrl.sv
module test_pwr_state_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       plat_rst_n = 1'b0;
    logic       hot_rst = 1'b0;
    logic       cfg_done = 1'b0;
    logic       cfg_apm_en = 1'b0;
    logic       cfg_mng_en = 1'b0;
    logic       cfg_pme_en = 1'b0;
    logic       cfg_pd_dis = 1'b0;
    logic       link_up = 1'b0;
    logic       pm_wr = 1'b0;
    logic [1:0] pm_wr_data = 2'b00;
    logic [2:0] state;
    logic       cfg_req;
    logic       phy_rst;
    logic       phy_slow;
    logic       wake_en;
    logic       lp_l3;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    pwr_state_ctrl i_pwr_state_ctrl (
        .clk        (clk),
        .rst        (rst),
        .plat_rst_n (plat_rst_n),
        .hot_rst    (hot_rst),
        .cfg_done   (cfg_done),
        .cfg_apm_en (cfg_apm_en),
        .cfg_mng_en (cfg_mng_en),
        .cfg_pme_en (cfg_pme_en),
        .cfg_pd_dis (cfg_pd_dis),
        .link_up    (link_up),
        .pm_wr      (pm_wr),
        .pm_wr_data (pm_wr_data),
        .state      (state),
        .cfg_req    (cfg_req),
        .phy_rst    (phy_rst),
        .phy_slow   (phy_slow),
        .wake_en    (wake_en),
        .lp_l3      (lp_l3)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; plat_rst_n = 1'b0; hot_rst = 1'b0; cfg_done = 1'b0;
        pm_wr = 1'b0; link_up = 1'b0;
        tick(); tick();
        rst = 1'b0;
        tick();
    endtask

    task automatic load_now(input logic apm);
        cfg_apm_en = apm;
        cfg_done = 1'b1;
        tick();
        cfg_done = 1'b0;
    endtask

    task automatic pm_write(input logic [1:0] v);
        pm_wr = 1'b1; pm_wr_data = v;
        tick();
        pm_wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog all-requirements actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        tick();
        // R1 during reset
        chk("R1", "state in reset", state, 0);
        chk("R1", "cfg_req in reset", cfg_req, 1);
        do_reset();
        chk("R1", "state after reset", state, 0);
        chk("R1", "cfg_req after reset", cfg_req, 1);
        chk("R1", "wake_en after reset", wake_en, 0);
        chk("R1", "phy_slow after reset", phy_slow, 0);
        chk("R1", "phy_rst after reset", phy_rst, 0);
        // R2: load still pending, so never held-off
        tick();
        chk("R2", "held while loading", state, 0);

        for (int i = 0; i < 16; i++) begin
            logic mng, pme, pd, apm, off, slow;
            mng = i[0]; pme = i[1]; pd = i[2]; apm = i[3];
            off  = !mng && !pme && pd;
            slow = mng | pme | apm;
            do_reset();
            cfg_mng_en = mng; cfg_pme_en = pme; cfg_pd_dis = pd;
            load_now(apm);
            chk("R4", "wake_en after held load", wake_en, apm);
            chk("R4", "phy_slow after held load", phy_slow, apm);
            chk("R2", "state at load edge", state, 0);
            chk("R6", "lp_l3", lp_l3, !pme);
            tick();
            chk("R2", "held-off decision", state, off ? 1 : 0);
            if (off) begin
                hot_rst = 1'b1; pm_wr = 1'b1; pm_wr_data = 2'b00;
                tick();
                hot_rst = 1'b0; pm_wr = 1'b0;
                chk("R3", "held-off ignores hot/write", state, 1);
            end
            plat_rst_n = 1'b1;
            tick();
            chk("R7", "uninit on plat release", state, 2);
            chk("R7", "cfg_req on entry", cfg_req, 1);
            chk("R7", "wake_en cleared", wake_en, 0);
            chk("R7", "phy_slow cleared", phy_slow, 0);
            chk("R8", "phy_rst while loading", phy_rst, 1);
            link_up = 1'b1;
            tick();
            chk("R9", "no active while loading", state, 2);
            load_now(apm);
            chk("R8", "wake_en reapplied", wake_en, apm);
            chk("R8", "phy_rst released", phy_rst, 0);
            chk("R9", "still uninit at load edge", state, 2);
            tick();
            chk("R9", "active after load and link", state, 3);
            pm_write(2'b00);
            chk("R10", "write 00 ignored in active", state, 3);
            pm_write(2'b01);
            chk("R10", "write 01 ignored", state, 3);
            pm_write(2'b10);
            chk("R10", "write 10 ignored", state, 3);
            pm_write(2'b11);
            chk("R10", "write 11 sleeps", state, 4);
            chk("R6", "lp_l3 in sleep", lp_l3, !pme);
            pm_write(2'b00);
            chk("R7", "write 00 wakes to uninit", state, 2);
            chk("R7", "wake_en cleared on wake", wake_en, 0);
            chk("R7", "cfg_req on wake", cfg_req, 1);
            load_now(apm);
            tick();
            chk("R9", "active again", state, 3);
            hot_rst = 1'b1;
            tick();
            hot_rst = 1'b0;
            chk("R7", "hot reset to uninit", state, 2);
            chk("R7", "cfg_req on hot reset", cfg_req, 1);
            load_now(apm);
            tick();
            chk("R9", "active after hot reset", state, 3);
            plat_rst_n = 1'b0; hot_rst = 1'b1; pm_wr = 1'b1; pm_wr_data = 2'b11;
            tick();
            hot_rst = 1'b0; pm_wr = 1'b0;
            chk("R11", "plat reset wins", state, 0);
            chk("R5", "phy_slow rule from active", phy_slow, slow);
            tick();
            chk("R2", "held-off after plat assert", state, off ? 1 : 0);
        end

        // R5 from sleep, with only APM wake set
        do_reset();
        cfg_mng_en = 1'b0; cfg_pme_en = 1'b0; cfg_pd_dis = 1'b0;
        load_now(1'b1);
        plat_rst_n = 1'b1; link_up = 1'b1;
        tick();
        load_now(1'b1);
        tick();
        pm_write(2'b11);
        chk("R10", "sleep reached", state, 4);
        plat_rst_n = 1'b0;
        tick();
        chk("R5", "held from sleep", state, 0);
        chk("R5", "phy_slow from wake only", phy_slow, 1);

        // R5 from uninit with nothing enabled
        do_reset();
        cfg_apm_en = 1'b0;
        load_now(1'b0);
        plat_rst_n = 1'b1;
        tick();
        chk("R7", "uninit entered", state, 2);
        plat_rst_n = 1'b0;
        tick();
        chk("R11", "held from uninit", state, 0);
        chk("R5", "phy_slow off when nothing enabled", phy_slow, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule